// File: doc/BRIEF.md
# Page-Mode DRAM Access Controller

This block turns single-supercell read and write requests from a CPU-side valid/ready port into row-strobe and column-strobe sequences for a small DRAM array. The array, modelled behaviourally inside the block, is a square grid of 8-bit supercells. The controller drives it through a narrow multiplexed address bus. A row strobe copies a whole row into a row buffer. A column strobe then reads or updates one supercell of that buffer.

The controller remembers which row sits in the row buffer. A request that lands in that row skips the row step and goes straight to the column strobe. Any other request first closes the row, which writes the buffer back to the array, and then opens the new one. A programmable refresh timer raises a refresh request. The controller serves it only between CPU requests: it closes any open row and then strobes every row in ascending order. Each request ends with a one-cycle response pulse that carries the data.

Top module: `fpdc_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, no DRAM strobe is active, and every supercell reads as zero.
- R2: The 4-bit request address splits into a row index in bits [3:2] and a column index in bits [1:0]. `dram_addr` carries the row index while `dram_ras` is high and the column index while `dram_cas` is high.
- R3: When no row is open, a request produces one row strobe followed in the next cycle by one column strobe. `rsp_valid` rises in the third cycle after the accepting clock edge.
- R4: A request to the open row produces no row strobe and no close strobe, only a column strobe. `rsp_valid` rises in the second cycle after the accepting edge.
- R5: A request to a row other than the open row produces a close strobe (`dram_pre`), then a row strobe, then a column strobe, one per cycle. `rsp_valid` rises in the fourth cycle after the accepting edge.
- R6: A read returns the stored supercell on `rsp_rdata`. A write returns the value it wrote.
- R7: A write goes into the row buffer, and closing the row stores the buffer back into the array. Written data survives a row change and a refresh.
- R8: `rsp_valid` is high for exactly one cycle per accepted request.
- R9: The refresh request is raised once the refresh counter reaches `refresh_interval`. While it is pending or being served, `req_ready` is 0, and a request already in flight finishes first.
- R10: Refresh closes an open row with `dram_pre` and then asserts `dram_ref` for rows 0, 1, 2, 3 in consecutive cycles. The next request after a refresh is treated as a request with no open row.
- R11: At most one of `dram_ras`, `dram_cas`, `dram_pre` and `dram_ref` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| refresh_interval | input | 16 | Cycles between refresh requests |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | 4 | Supercell address: row [3:2], column [1:0] |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 8 | Read data, or the written value for a write |
| dram_ras | output | 1 | Row strobe to the array |
| dram_cas | output | 1 | Column strobe to the array |
| dram_pre | output | 1 | Row close (buffer write-back) strobe |
| dram_ref | output | 1 | Refresh strobe for the row on `dram_addr` |
| dram_addr | output | 2 | Multiplexed row/column address |

## Verification
The hardest case to reach is a refresh request that arrives while a CPU access is partway through its strobe sequence, or while a request is waiting to be accepted. The port timing alone rarely lines these up. To force the collision, the bench sets the refresh interval to a few cycles and sends a long stream of reads over rows that keep changing. Under that pressure it checks that every response still carries the right data. Separate directed tasks open a row, let the refresh close it, and then check the strobe order and that the next access takes the row-miss latency.

// File: rtl/fpdc_pkg.sv
// Shared types for the page-mode DRAM controller.
// Assumes row and column indices are narrow (a few bits each).
package fpdc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PRE  = 3'd1,
        ST_RAS  = 3'd2,
        ST_CAS  = 3'd3,
        ST_RPRE = 3'd4,
        ST_REF  = 3'd5
    } seq_state_t;
endpackage

// File: rtl/fpdc_refresh_timer.sv
// Refresh timer: counts cycles and raises a refresh request once the count
// reaches the programmed interval; the request stays up until acknowledged.
// Assumes the interval input is quasi-static.
module fpdc_refresh_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] interval,
    input  logic             ack,
    output logic             pending
);
    logic [CNT_W-1:0] cnt_q;
    logic             hit;

    // Interval reached (>= so a lowered interval takes effect at once).
    assign hit = (cnt_q >= interval);

    // Cycle counter, restarting each time a request is raised.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt_q <= '0;
        else if (hit) cnt_q <= '0;
        else          cnt_q <= cnt_q + 1'b1;
    end

    // Pending flag: set on interval, cleared on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)   pending <= 1'b0;
        else if (hit) pending <= 1'b1;
        else if (ack) pending <= 1'b0;
    end

    // R9: the request is raised one cycle after the counter reaches the interval.
    assert_pending_on_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> pending);
endmodule

// File: rtl/fpdc_dram_model.sv
// Behavioural DRAM array with a single row buffer. A row strobe loads the
// buffer from the array, a column strobe reads or updates one supercell of
// the buffer, and a close strobe writes the buffer back into the array.
// Assumes the controller strobes one command per cycle.
module fpdc_dram_model #(
    parameter int ROW_BITS = 2,
    parameter int COL_BITS = 2,
    parameter int DATA_W   = 8,
    parameter int DADDR_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ras,
    input  logic               cas,
    input  logic               pre,
    input  logic               we,
    input  logic [DADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata
);
    localparam int ROWS = 1 << ROW_BITS;
    localparam int COLS = 1 << COL_BITS;

    logic [ROWS-1:0][COLS-1:0][DATA_W-1:0] array_q;
    logic [COLS-1:0][DATA_W-1:0]           rowbuf_q;
    logic [ROW_BITS-1:0]                   buf_row_q;
    logic                                  buf_open_q;
    logic [ROW_BITS-1:0]                   row_idx;
    logic [COL_BITS-1:0]                   col_idx;

    assign row_idx = addr[ROW_BITS-1:0];
    assign col_idx = addr[COL_BITS-1:0];

    // Cell array: cleared at reset, updated from the buffer on a close.
    always_ff @(posedge clk) begin
        if (!rst_n)                 array_q <= '0;
        else if (pre && buf_open_q) array_q[buf_row_q] <= rowbuf_q;
    end

    // Row buffer: filled on a row strobe, patched on a column write.
    always_ff @(posedge clk) begin
        if (!rst_n)           rowbuf_q <= '0;
        else if (ras)         rowbuf_q <= array_q[row_idx];
        else if (cas && we)   rowbuf_q[col_idx] <= wdata;
    end

    // Buffer bookkeeping: which row is held and whether it is live.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_row_q  <= '0;
            buf_open_q <= 1'b0;
        end else if (ras) begin
            buf_row_q  <= row_idx;
            buf_open_q <= 1'b1;
        end else if (pre) begin
            buf_open_q <= 1'b0;
        end
    end

    // Data lines: the selected supercell, or the written value on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)   rdata <= '0;
        else if (cas) rdata <= we ? wdata : rowbuf_q[col_idx];
    end

    // R3: a column strobe is only ever issued into an open row buffer.
    assert_cas_into_open_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cas |-> buf_open_q);
    // R7: a close only happens when a row is held in the buffer.
    assert_pre_has_row_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pre |-> buf_open_q);
endmodule

// File: rtl/fpdc_sequencer.sv
// Strobe sequencer: accepts CPU requests, tracks the open row, and issues
// close/row/column strobes; serves refresh between requests by closing the
// open row and strobing every row in ascending order.
// Assumes the request fields stay stable while req_valid is high.
module fpdc_sequencer
    import fpdc_pkg::*;
#(
    parameter int ROW_BITS = 2,
    parameter int COL_BITS = 2,
    parameter int DATA_W   = 8,
    parameter int DADDR_W  = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [ROW_BITS+COL_BITS-1:0] req_addr,
    input  logic                         req_write,
    input  logic [DATA_W-1:0]            req_wdata,
    input  logic                         ref_pending,
    output logic                         ref_ack,
    output logic                         rsp_valid,
    output logic                         dram_ras,
    output logic                         dram_cas,
    output logic                         dram_pre,
    output logic                         dram_ref,
    output logic                         dram_we,
    output logic [DADDR_W-1:0]           dram_addr,
    output logic [DATA_W-1:0]            dram_wdata
);
    localparam int ROWS = 1 << ROW_BITS;

    seq_state_t          state_q, state_d;
    logic [ROW_BITS-1:0] cur_row_q, open_row_q, ref_row_q;
    logic [COL_BITS-1:0] cur_col_q;
    logic                cur_we_q, open_valid_q;
    logic [DATA_W-1:0]   cur_wd_q;
    logic [ROW_BITS-1:0] req_row;
    logic [COL_BITS-1:0] req_col;
    logic                accept, row_hit, ref_last;

    assign req_row  = req_addr[ROW_BITS+COL_BITS-1:COL_BITS];
    assign req_col  = req_addr[COL_BITS-1:0];
    assign req_ready = (state_q == ST_IDLE) && !ref_pending;
    assign accept   = req_valid && req_ready;
    assign row_hit  = open_valid_q && (open_row_q == req_row);
    assign ref_last = (state_q == ST_REF) && (ref_row_q == ROW_BITS'(ROWS - 1));
    assign ref_ack  = ref_last;

    // Next-state choice for the strobe sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_pending)  state_d = open_valid_q ? ST_RPRE : ST_REF;
                else if (accept)  state_d = row_hit ? ST_CAS : (open_valid_q ? ST_PRE : ST_RAS);
            end
            ST_PRE:  state_d = ST_RAS;
            ST_RAS:  state_d = ST_CAS;
            ST_CAS:  state_d = ST_IDLE;
            ST_RPRE: state_d = ST_REF;
            ST_REF:  state_d = ref_last ? ST_IDLE : ST_REF;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Latch the accepted request for the rest of its sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_row_q <= '0;
            cur_col_q <= '0;
            cur_we_q  <= 1'b0;
            cur_wd_q  <= '0;
        end else if (accept) begin
            cur_row_q <= req_row;
            cur_col_q <= req_col;
            cur_we_q  <= req_write;
            cur_wd_q  <= req_wdata;
        end
    end

    // Open-row tracker: set by a row strobe, cleared by any close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_row_q   <= '0;
            open_valid_q <= 1'b0;
        end else if (state_q == ST_RAS) begin
            open_row_q   <= cur_row_q;
            open_valid_q <= 1'b1;
        end else if (state_q == ST_PRE || state_q == ST_RPRE) begin
            open_valid_q <= 1'b0;
        end
    end

    // Refresh row walker: restarts at row 0 before each refresh burst.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ref_row_q <= '0;
        else if (state_q == ST_REF) ref_row_q <= ref_row_q + 1'b1;
        else                        ref_row_q <= '0;
    end

    // Response pulse, one cycle after the column strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_valid <= 1'b0;
        else        rsp_valid <= (state_q == ST_CAS);
    end

    // Strobe and address drive for the array.
    always_comb begin
        dram_ras   = (state_q == ST_RAS);
        dram_cas   = (state_q == ST_CAS);
        dram_pre   = (state_q == ST_PRE) || (state_q == ST_RPRE);
        dram_ref   = (state_q == ST_REF);
        dram_we    = dram_cas && cur_we_q;
        dram_wdata = cur_wd_q;
        dram_addr  = '0;
        if (dram_ras)      dram_addr = DADDR_W'(cur_row_q);
        else if (dram_cas) dram_addr = DADDR_W'(cur_col_q);
        else if (dram_ref) dram_addr = DADDR_W'(ref_row_q);
    end

    // R11: strobes never overlap.
    assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dram_ras, dram_cas, dram_pre, dram_ref}));
    // R3: a row strobe is followed by a column strobe.
    assert_ras_then_cas_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dram_ras |=> dram_cas);
    // R5: a close is followed by a row open or a refresh strobe.
    assert_pre_then_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dram_pre |=> (dram_ras || dram_ref));
    // R8: the response is a single-cycle pulse.
    assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R9: no request is accepted while refresh is pending.
    assert_no_accept_in_refresh_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pending |-> !req_ready);
    // R10: refresh strobes walk the rows in ascending order.
    assert_ref_ascending_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_ref && $past(dram_ref)) |-> (dram_addr == $past(dram_addr) + 1'b1));
    // R4: a row hit goes directly from idle to a column strobe without a row strobe.
    assert_hit_skips_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && row_hit && !ref_pending) |=> (dram_cas && !$past(dram_ras)));
endmodule

// File: rtl/fpdc_ctrl.sv
// Top of the page-mode DRAM controller: sequencer, refresh timer and the
// behavioural array. The array strobes are brought out for observation.
// Assumes a single requester and a single bank.
module fpdc_ctrl #(
    parameter int ROW_BITS = 2,
    parameter int COL_BITS = 2,
    parameter int DATA_W   = 8,
    parameter int CNT_W    = 16,
    localparam int ADDR_W  = ROW_BITS + COL_BITS,
    localparam int DADDR_W = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   refresh_interval,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_write,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               dram_ras,
    output logic               dram_cas,
    output logic               dram_pre,
    output logic               dram_ref,
    output logic [DADDR_W-1:0] dram_addr
);
    logic              ref_pending, ref_ack, dram_we;
    logic [DATA_W-1:0] dram_wdata;

    fpdc_refresh_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .interval(refresh_interval),
        .ack(ref_ack), .pending(ref_pending)
    );

    fpdc_sequencer #(
        .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DATA_W(DATA_W), .DADDR_W(DADDR_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata),
        .ref_pending(ref_pending), .ref_ack(ref_ack), .rsp_valid(rsp_valid),
        .dram_ras(dram_ras), .dram_cas(dram_cas), .dram_pre(dram_pre),
        .dram_ref(dram_ref), .dram_we(dram_we), .dram_addr(dram_addr),
        .dram_wdata(dram_wdata)
    );

    fpdc_dram_model #(
        .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DATA_W(DATA_W), .DADDR_W(DADDR_W)
    ) u_array (
        .clk(clk), .rst_n(rst_n),
        .ras(dram_ras), .cas(dram_cas), .pre(dram_pre), .we(dram_we),
        .addr(dram_addr), .wdata(dram_wdata), .rdata(rsp_rdata)
    );
endmodule

// File: tb/fpdc_ctrl_tb.sv
`timescale 1ns/1ps
module fpdc_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] refresh_interval = 16'd60000;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid, dram_ras, dram_cas, dram_pre, dram_ref;
    logic [7:0]  rsp_rdata;
    logic [1:0]  dram_addr;
    int checks = 0, errors = 0;
    bit done = 0;

    fpdc_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .refresh_interval(refresh_interval),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .dram_ras(dram_ras), .dram_cas(dram_cas), .dram_pre(dram_pre),
        .dram_ref(dram_ref), .dram_addr(dram_addr)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One access; exp_lat < 0 skips strobe and latency checks.
    task automatic do_access(input logic [3:0] a, input bit wr, input logic [7:0] wd,
                             input int exp_lat, input int exp_pre, input int exp_ras,
                             input logic [7:0] exp_d);
        int lat = 0, npre = 0, nras = 0, ras_a = -1, cas_a = -1;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_wdata = wd;
        for (int w = 0; w < 100 && !req_ready; w++) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 20; k++) begin
            lat++;
            if (dram_ras) begin nras++; ras_a = dram_addr; end
            if (dram_pre) npre++;
            if (dram_cas) cas_a = dram_addr;
            if (rsp_valid) break;
            @(negedge clk);
        end
        check(rsp_valid, "R6 response seen", rsp_valid, 1);
        check(rsp_rdata == exp_d, "R6 data", rsp_rdata, exp_d);
        if (exp_lat >= 0) begin
            check(lat == exp_lat, "R3/R4/R5 latency", lat, exp_lat);
            check(npre == exp_pre, "R5 close strobes", npre, exp_pre);
            check(nras == exp_ras, "R4 row strobes", nras, exp_ras);
            check(cas_a == a[1:0], "R2 column address", cas_a, a[1:0]);
            if (exp_ras > 0) check(ras_a == a[3:2], "R2 row address", ras_a, a[3:2]);
        end
        @(negedge clk);
        check(!rsp_valid, "R8 single pulse", rsp_valid, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(req_ready, "R1 ready after reset", req_ready, 1);
        check(!rsp_valid, "R1 no response", rsp_valid, 0);
        check({dram_ras, dram_cas, dram_pre, dram_ref} == 4'b0, "R1 strobes idle",
              {dram_ras, dram_cas, dram_pre, dram_ref}, 0);
    endtask

    task automatic t_cold_miss();   // R3, R1 zeroed array
        do_access(4'h6, 1'b0, 8'h00, 3, 0, 1, 8'h00);
    endtask

    task automatic t_row_hit();     // R4, R6
        do_access(4'h5, 1'b1, 8'hA5, 2, 0, 0, 8'hA5);
        do_access(4'h5, 1'b0, 8'h00, 2, 0, 0, 8'hA5);
    endtask

    task automatic t_conflict();    // R5, R7 write-back
        do_access(4'hB, 1'b0, 8'h00, 4, 1, 1, 8'h00);
        do_access(4'h5, 1'b0, 8'h00, 4, 1, 1, 8'hA5);
    endtask

    task automatic t_fill();        // R6, R7 across rows
        for (int a = 0; a < 16; a++)
            do_access(4'(a), 1'b1, 8'(a * 13 + 7), -1, 0, 0, 8'(a * 13 + 7));
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                do_access(4'(r * 4 + c), 1'b0, 8'h00, -1, 0, 0, 8'(r * 4 + c) * 8'd13 + 8'd7);
    endtask

    task automatic t_refresh();     // R9, R10, R7
        int seen_pre = 0, nref = 0, order_ok = 1, ready_bad = 0;
        do_access(4'h9, 1'b1, 8'h3C, 4, 1, 1, 8'h3C);
        refresh_interval = 16'd20;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (dram_pre && nref == 0) seen_pre = 1;
            if (dram_ref) begin
                if (dram_addr != 2'(nref)) order_ok = 0;
                if (req_ready) ready_bad = 1;
                nref++;
            end
            if (nref == 4) break;
        end
        refresh_interval = 16'd60000;
        check(seen_pre == 1, "R10 close before refresh", seen_pre, 1);
        check(nref == 4, "R10 rows refreshed", nref, 4);
        check(order_ok == 1, "R10 ascending order", order_ok, 1);
        check(ready_bad == 0, "R9 not ready in refresh", ready_bad, 0);
        do_access(4'h9, 1'b0, 8'h00, 3, 0, 1, 8'h3C);
    endtask

    task automatic t_refresh_stress();  // R9, R7 under collisions
        refresh_interval = 16'd5;
        for (int i = 0; i < 24; i++)
            do_access(4'((i * 7) % 16), 1'b0, 8'h00, -1, 0, 0,
                      ((i * 7) % 16 == 9) ? 8'h3C : ((i * 7) % 16 == 5) ? 8'h5A
                      : 8'(((i * 7) % 16) * 13 + 7));
        refresh_interval = 16'd60000;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_cold_miss();
        t_row_hit();
        t_conflict();
        t_fill();
        do_access(4'h5, 1'b1, 8'h5A, -1, 0, 0, 8'h5A);
        t_refresh();
        t_refresh_stress();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule